// File: doc/BRIEF.md
# Processor Bus Takeover Master

This block lets an on-chip agent borrow the external bus of an 8-bit microprocessor. It asks for the bus with an active-low request line and waits for the processor's active-low acknowledge. Once it holds the bus, it runs one of three memory transactions on a 19-bit address bus and an 8-bit bidirectional data bus:

- a single read;
- a single write;
- a fill, which writes one byte to a run of consecutive addresses.

It then hands the bus back in a fixed order and waits for the processor to confirm that it has the bus again.

The user side takes one command per handshake. It presents a command strobe, a 2-bit opcode, an address, a write byte and a fill length. It gets back a busy level, a one-cycle done strobe, an error flag and the byte read. Every access is wrapped in its own takeover and hand-back, so the processor is never held off longer than one command takes. A wait for acknowledge that runs past `ACK_WAIT` cycles raises the error flag, so the block does not hang.

The controller is one state machine. Its states are:

- IDLE
- REQ: request asserted, waiting for acknowledge
- DRIVE_ADDR: address enabled
- MEN_ON: memory enable asserted
- DATA_OUT: data bus turned to output
- WR_LO and WR_HI: the write strobe pulse
- ADV: fill address step
- RD_1 and RD_2: read strobe low
- RD_OFF: read strobe released
- MEN_OFF: memory enable released
- REL_DATA: data bus back to input
- REL_ADDR: address floated
- REL_WAIT: request released, waiting for acknowledge to go high
- FIN: done

Its transitions are:

- IDLE to REQ on an access command.
- IDLE to REL_WAIT on a release command.
- REQ to DRIVE_ADDR on acknowledge.
- REQ to REL_WAIT on timeout.
- DRIVE_ADDR to MEN_ON.
- MEN_ON to RD_1 for a read, or to DATA_OUT for a write or fill.
- DATA_OUT to WR_LO, then WR_LO to WR_HI.
- WR_HI to ADV while fill bytes remain, otherwise to MEN_OFF.
- ADV to WR_LO.
- RD_1 to RD_2 to RD_OFF to MEN_OFF.
- MEN_OFF to REL_DATA to REL_ADDR to REL_WAIT.
- REL_WAIT to FIN on acknowledge high or on timeout.
- FIN to IDLE.

Top module: `bus_takeover_master`

## Requirements
- R1: After reset, and whenever idle, the request, memory-enable, read and write outputs are high, both output enables are low, and busy and done are low.
- R2: For an access command, the request goes low first. The address enable rises only after acknowledge has been sampled low. The memory strobes are active only while acknowledge is low, and the request falls exactly once per access.
- R3: The hand-back runs in a fixed order. The data enable drops first, then the address enable, then the request goes high. Done comes only after acknowledge is sampled high again.
- R4: A write (opcode 01) asserts memory enable before the data enable, and the data stays driven while write is low. Write pulses low for exactly one cycle, and memory enable goes high after that pulse. The byte lands at the full 19-bit address.
- R5: A read (opcode 00) holds read low for exactly two cycles inside a memory-enable window, with the data enable low. It returns the bus byte sampled while read is low on the read-data output, valid from done onward.
- R6: A fill (opcode 10) asserts memory enable once and pulses write `cmd_len`+1 times with the same byte. The address steps up by one per pulse, so the last byte lands at `cmd_addr`+`cmd_len`.
- R7: If acknowledge does not go low within `ACK_WAIT` cycles, the block releases the request, raises the error flag and signals done without any memory strobe. Accepting the next command clears the error flag.
- R8: Busy is high from the cycle after a command is accepted through the done cycle. Done is a single-cycle pulse. A command strobe seen while busy is ignored.
- R9: A release command (opcode 11) drives the request high and waits for acknowledge high. It issues no memory strobe and enables neither bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken only while idle |
| cmd_op | input | 2 | 00 read, 01 write, 10 fill, 11 release |
| cmd_addr | input | 19 | Start address |
| cmd_wdata | input | 8 | Byte to write or fill with |
| cmd_len | input | 8 | Fill length minus one |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | Acknowledge wait timed out |
| rdata | output | 8 | Byte returned by a read |
| breq_n | output | 1 | Bus request, active low |
| bus_ack_n | input | 1 | Bus acknowledge, active low |
| mreq_n | output | 1 | Memory enable, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| addr_o | output | 19 | Address value |
| addr_oe | output | 1 | Address bus drive enable |
| data_o | output | 8 | Write data value |
| data_oe | output | 1 | Data bus drive enable |
| data_i | input | 8 | Data bus input |

## Verification
The bench goes after the following cases:

- **Hand-back order.** A design that floats the address after raising the request would fight the processor on the address lines. The bench counts any cycle where an enable is high while acknowledge or request says the bus is not owned.
- **Fill.** A fill that re-asserts memory enable per byte, or drops a pulse, shows up in the memory-enable and write-pulse counts. The same happens if the fill lands off by one at the last address.
- **Top address.** An access at 0x7FFFF exposes a truncated address counter.
- **Dead acknowledge.** A hung wait trips the per-command watchdog. A design that strobes memory without ownership shows up in the strobe counts.
- **Command during busy.** A command strobe pulsed mid-access must leave its target byte untouched.

// File: rtl/bt_pkg.sv
package bt_pkg;

    typedef enum logic [1:0] {
        OP_READ    = 2'd0,
        OP_WRITE   = 2'd1,
        OP_FILL    = 2'd2,
        OP_RELEASE = 2'd3
    } bt_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_REQ,
        ST_DRIVE_ADDR,
        ST_MEN_ON,
        ST_DATA_OUT,
        ST_WR_LO,
        ST_WR_HI,
        ST_ADV,
        ST_RD_1,
        ST_RD_2,
        ST_RD_OFF,
        ST_MEN_OFF,
        ST_REL_DATA,
        ST_REL_ADDR,
        ST_REL_WAIT,
        ST_FIN
    } bt_state_e;

endpackage

// File: rtl/bt_ack_timer.sv
// Counts cycles spent waiting on the acknowledge line; flags the last allowed cycle.
module bt_ack_timer #(
    parameter int WAIT_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic clr_i,
    output logic expired_o
);
    localparam int CW = $clog2(WAIT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(WAIT_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i || !run_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/bt_addr_seq.sv
// Holds the bus address and the number of bytes still to go in a fill.
module bt_addr_seq #(
    parameter int ADDR_W = 19,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              last_o
);
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  rem_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            rem_q  <= '0;
        end else if (load_i) begin
            addr_q <= addr_i;
            rem_q  <= len_i;
        end else if (step_i) begin
            addr_q <= addr_q + 1'b1;
            rem_q  <= rem_q - 1'b1;
        end
    end

    assign addr_o = addr_q;
    assign last_o = (rem_q == '0);

endmodule

// File: rtl/bus_takeover_master.sv
module bus_takeover_master
    import bt_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int DATA_W   = 8,
    parameter int LEN_W    = 8,
    parameter int ACK_WAIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic [LEN_W-1:0]  cmd_len,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rdata,
    output logic              breq_n,
    input  logic              bus_ack_n,
    output logic              mreq_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [ADDR_W-1:0] addr_o,
    output logic              addr_oe,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe,
    input  logic [DATA_W-1:0] data_i
);
    bt_state_e         state_q, state_d;
    bt_op_e            op_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              err_q;
    logic              accept;
    logic              ack_expired;
    logic              wait_run;
    logic              fill_last;
    logic              step_addr;
    logic              timeout_hit;

    assign accept    = (state_q == ST_IDLE) && cmd_valid;
    assign wait_run  = (state_q == ST_REQ) || (state_q == ST_REL_WAIT);
    assign step_addr = (state_q == ST_WR_HI) && (state_d == ST_ADV);

    assign timeout_hit = ((state_q == ST_REQ) && bus_ack_n && ack_expired) ||
                         ((state_q == ST_REL_WAIT) && !bus_ack_n && ack_expired);

    bt_ack_timer #(
        .WAIT_CYC (ACK_WAIT)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (wait_run),
        .clr_i     (state_q != state_d),
        .expired_o (ack_expired)
    );

    bt_addr_seq #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept),
        .addr_i (cmd_addr),
        .len_i  ((bt_op_e'(cmd_op) == OP_FILL) ? cmd_len : '0),
        .step_i (step_addr),
        .addr_o (addr_o),
        .last_o (fill_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Command and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= OP_READ;
            wdata_q <= '0;
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            if (accept) begin
                op_q    <= bt_op_e'(cmd_op);
                wdata_q <= cmd_wdata;
                err_q   <= 1'b0;
            end else if (timeout_hit) begin
                err_q   <= 1'b1;
            end
            if (state_q == ST_RD_2) begin
                rdata_q <= data_i;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    state_d = (bt_op_e'(cmd_op) == OP_RELEASE) ? ST_REL_WAIT : ST_REQ;
                end
            end
            ST_REQ: begin
                if (!bus_ack_n) begin
                    state_d = ST_DRIVE_ADDR;
                end else if (ack_expired) begin
                    state_d = ST_REL_WAIT;
                end
            end
            ST_DRIVE_ADDR: state_d = ST_MEN_ON;
            ST_MEN_ON:     state_d = (op_q == OP_READ) ? ST_RD_1 : ST_DATA_OUT;
            ST_DATA_OUT:   state_d = ST_WR_LO;
            ST_WR_LO:      state_d = ST_WR_HI;
            ST_WR_HI: begin
                state_d = (op_q == OP_FILL && !fill_last) ? ST_ADV : ST_MEN_OFF;
            end
            ST_ADV:        state_d = ST_WR_LO;
            ST_RD_1:       state_d = ST_RD_2;
            ST_RD_2:       state_d = ST_RD_OFF;
            ST_RD_OFF:     state_d = ST_MEN_OFF;
            ST_MEN_OFF:    state_d = ST_REL_DATA;
            ST_REL_DATA:   state_d = ST_REL_ADDR;
            ST_REL_ADDR:   state_d = ST_REL_WAIT;
            ST_REL_WAIT: begin
                if (bus_ack_n || ack_expired) begin
                    state_d = ST_FIN;
                end
            end
            ST_FIN:        state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        breq_n  = 1'b1;
        addr_oe = 1'b0;
        mreq_n  = 1'b1;
        rd_n    = 1'b1;
        wr_n    = 1'b1;
        data_oe = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_REL_WAIT, ST_FIN: begin
            end
            ST_REQ: begin
                breq_n = 1'b0;
            end
            ST_DRIVE_ADDR: begin
                breq_n  = 1'b0;
                addr_oe = 1'b1;
            end
            ST_MEN_ON, ST_RD_OFF: begin
                breq_n  = 1'b0;
                addr_oe = 1'b1;
                mreq_n  = 1'b0;
            end
            ST_RD_1, ST_RD_2: begin
                breq_n  = 1'b0;
                addr_oe = 1'b1;
                mreq_n  = 1'b0;
                rd_n    = 1'b0;
            end
            ST_DATA_OUT, ST_WR_HI, ST_ADV: begin
                breq_n  = 1'b0;
                addr_oe = 1'b1;
                mreq_n  = 1'b0;
                data_oe = 1'b1;
            end
            ST_WR_LO: begin
                breq_n  = 1'b0;
                addr_oe = 1'b1;
                mreq_n  = 1'b0;
                data_oe = 1'b1;
                wr_n    = 1'b0;
            end
            ST_MEN_OFF: begin
                breq_n  = 1'b0;
                addr_oe = 1'b1;
                data_oe = (op_q != OP_READ);
            end
            ST_REL_DATA: begin
                breq_n  = 1'b0;
                addr_oe = 1'b1;
            end
            ST_REL_ADDR: begin
                breq_n  = 1'b0;
            end
            default: begin
            end
        endcase
    end

    assign busy   = (state_q != ST_IDLE);
    assign done   = (state_q == ST_FIN);
    assign err    = err_q;
    assign rdata  = rdata_q;
    assign data_o = wdata_q;

endmodule

// File: rtl/bt_bus_checker.sv
module bt_bus_checker (
    input logic clk,
    input logic rst_n,
    input logic bus_ack_n,
    input logic breq_n,
    input logic mreq_n,
    input logic rd_n,
    input logic wr_n,
    input logic addr_oe,
    input logic data_oe,
    input logic busy,
    input logic done
);
    p_addr_after_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_oe) |-> $past(!bus_ack_n));

    p_strobe_needs_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> (!bus_ack_n && !breq_n));

    p_addr_off_after_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(addr_oe) |-> ($past(!data_oe) && !data_oe));

    p_breq_up_after_float_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(breq_n) |-> (!addr_oe && !data_oe));

    p_wr_framed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> (!mreq_n && data_oe));

    p_wr_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_n) |=> wr_n);

    p_rd_framed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> (!mreq_n && !data_oe));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_while_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

endmodule

bind bus_takeover_master bt_bus_checker u_chk (.*);

// File: tb/bus_takeover_master_tb.sv
module bus_takeover_master_tb;

    localparam int AW = 19;
    localparam int DW = 8;
    localparam int LW = 8;
    localparam int VW = 2 + AW + DW + LW + DW + 1;
    localparam int NV = 10;

    // {op, addr, wdata, len, expected read, check read}
    localparam logic [VW-1:0] VEC [NV] = '{
        {2'd1, 19'h12345, 8'h3C, 8'd0, 8'h00, 1'b0},
        {2'd0, 19'h12345, 8'h00, 8'd0, 8'h3C, 1'b1},
        {2'd2, 19'h40010, 8'hA5, 8'd3, 8'h00, 1'b0},
        {2'd0, 19'h40012, 8'h00, 8'd0, 8'hA5, 1'b1},
        {2'd0, 19'h40013, 8'h00, 8'd0, 8'hA5, 1'b1},
        {2'd0, 19'h40014, 8'h00, 8'd0, 8'h4E, 1'b1},
        {2'd1, 19'h7FFFF, 8'h81, 8'd0, 8'h00, 1'b0},
        {2'd0, 19'h7FFFF, 8'h00, 8'd0, 8'h81, 1'b1},
        {2'd0, 19'h00000, 8'h00, 8'd0, 8'h5A, 1'b1},
        {2'd3, 19'h00000, 8'h00, 8'd0, 8'h00, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'd0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic [LW-1:0] cmd_len = '0;
    logic          busy, done, err;
    logic [DW-1:0] rdata;
    logic          breq_n, mreq_n, rd_n, wr_n, addr_oe, data_oe;
    logic          bus_ack_n = 1'b1;
    logic [AW-1:0] addr_o;
    logic [DW-1:0] data_o;
    logic [DW-1:0] data_i;

    logic [DW-1:0] mem [256];
    logic          ack_dead = 1'b0;
    logic          breq_d1 = 1'b1;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    int men_falls, wr_rises, rd_cycles, req_falls, viol;
    logic [AW-1:0] last_wa;
    logic prev_mreq = 1'b1, prev_wr = 1'b1, prev_breq = 1'b1;

    always #2 clk = ~clk;

    bus_takeover_master u_dut (
        .clk (clk), .rst_n (rst_n),
        .cmd_valid (cmd_valid), .cmd_op (cmd_op), .cmd_addr (cmd_addr),
        .cmd_wdata (cmd_wdata), .cmd_len (cmd_len),
        .busy (busy), .done (done), .err (err), .rdata (rdata),
        .breq_n (breq_n), .bus_ack_n (bus_ack_n), .mreq_n (mreq_n),
        .rd_n (rd_n), .wr_n (wr_n), .addr_o (addr_o), .addr_oe (addr_oe),
        .data_o (data_o), .data_oe (data_oe), .data_i (data_i)
    );

    // Processor model: acknowledge follows the request two cycles later.
    always @(posedge clk) begin
        breq_d1   <= breq_n;
        bus_ack_n <= ack_dead ? 1'b1 : breq_d1;
    end

    assign data_i = (!rd_n && !data_oe) ? mem[addr_o[7:0]] : 8'h00;

    // Bus monitor, sampled between edges
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (prev_mreq && !mreq_n) men_falls <= men_falls + 1;
        if (prev_breq && !breq_n) req_falls <= req_falls + 1;
        if (!rd_n) rd_cycles <= rd_cycles + 1;
        if (!prev_wr && wr_n) begin
            wr_rises <= wr_rises + 1;
            mem[addr_o[7:0]] <= data_o;
            last_wa <= addr_o;
        end
        if ((addr_oe && (bus_ack_n || breq_n)) || (data_oe && !addr_oe) ||
            (!mreq_n && !addr_oe) || (!rd_n && data_oe))
            viol <= viol + 1;
        prev_mreq <= mreq_n;
        prev_wr   <= wr_n;
        prev_breq <= breq_n;
    end

    initial begin
        while (cyc < 150000) @(negedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run hung, actual cycles=%0d expected < 150000", cyc);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic run_cmd(input logic [1:0] op, input logic [AW-1:0] a,
                           input logic [DW-1:0] d, input logic [LW-1:0] l,
                           input bit poke_busy);
        int waited;
        @(negedge clk);
        men_falls = 0; wr_rises = 0; rd_cycles = 0; req_falls = 0; viol = 0;
        cmd_op = op; cmd_addr = a; cmd_wdata = d; cmd_len = l; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R8 busy after accept", 32'(busy), 32'd1);
        waited = 0;
        while (!done && waited < 1000) begin
            if (poke_busy && waited == 3) begin
                cmd_op = 2'd1; cmd_addr = 19'h00033; cmd_wdata = 8'hEE; cmd_valid = 1'b1;
            end else begin
                cmd_valid = 1'b0;
            end
            @(negedge clk);
            waited++;
        end
        cmd_valid = 1'b0;
        check("R8 done reached", 32'(done), 32'd1);
        check("R3 request high at done", 32'(breq_n), 32'd1);
        @(negedge clk);
        check("R8 done single cycle", 32'(done), 32'd0);
        check("R1 idle after done", {busy, breq_n, mreq_n, rd_n, wr_n, addr_oe, data_oe},
              32'b0111100);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {busy, done, err, breq_n, mreq_n, rd_n, wr_n, addr_oe, data_oe},
              32'b000111100);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            logic [1:0]    op  = VEC[v][VW-1 -: 2];
            logic [AW-1:0] a   = VEC[v][VW-3 -: AW];
            logic [DW-1:0] d   = VEC[v][VW-3-AW -: DW];
            logic [LW-1:0] l   = VEC[v][VW-3-AW-DW -: LW];
            logic [DW-1:0] exp = VEC[v][DW:1];
            logic          chk = VEC[v][0];
            run_cmd(op, a, d, l, (v == 0));
            check("R2 R3 ownership order", 32'(viol), 32'd0);
            if (op == 2'd3) begin
                check("R9 release no strobes", 32'(men_falls + wr_rises + rd_cycles + req_falls), 32'd0);
            end else begin
                check("R2 one request per access", 32'(req_falls), 32'd1);
                check("R6 one memory enable", 32'(men_falls), 32'd1);
                check("R7 no error on good ack", 32'(err), 32'd0);
            end
            if (op == 2'd0) begin
                check("R5 read strobe two cycles", 32'(rd_cycles), 32'd2);
                if (chk) check("R5 read data", 32'(rdata), 32'(exp));
            end
            if (op == 2'd1 || op == 2'd2) begin
                check("R6 write pulse count", 32'(wr_rises), 32'(l) + 32'd1);
                check("R4 last write address", 32'(last_wa), 32'(a + 19'(l)));
            end
        end

        // R8: the command poked mid-access must not have written 0x33
        run_cmd(2'd0, 19'h00033, 8'h00, 8'd0, 1'b0);
        check("R8 busy command ignored", 32'(rdata), 32'h69);

        // R6: fill of one byte (len 0) touches only its own address
        run_cmd(2'd2, 19'h00050, 8'h77, 8'd0, 1'b0);
        check("R6 single fill pulse", 32'(wr_rises), 32'd1);
        run_cmd(2'd0, 19'h00051, 8'h00, 8'd0, 1'b0);
        check("R6 fill stops at end", 32'(rdata), 32'h0B);

        // R7: acknowledge never comes
        ack_dead = 1'b1;
        run_cmd(2'd1, 19'h00060, 8'hC3, 8'd0, 1'b0);
        check("R7 error flag", 32'(err), 32'd1);
        check("R7 no strobes on timeout", 32'(men_falls + wr_rises), 32'd0);
        check("R7 no bus drive on timeout", 32'(viol), 32'd0);
        ack_dead = 1'b0;
        repeat (4) @(negedge clk);
        run_cmd(2'd3, 19'h00000, 8'h00, 8'd0, 1'b0);
        check("R7 error cleared by next command", 32'(err), 32'd0);
        check("R9 release quiet", 32'(men_falls + wr_rises + rd_cycles), 32'd0);
        run_cmd(2'd0, 19'h00060, 8'h00, 8'd0, 1'b0);
        check("R7 timed-out write left memory", 32'(rdata), 32'h3A);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule